// File: doc/BRIEF.md
# UART Bit-Rate Generator with Receive Idle Timeout

This block sits next to a UART's serial engines. It makes the bit-rate tick that paces them, and it raises a one-cycle idle event after the receive line has been quiet for a while. The tick period in core clocks is the product of three factors. The first is an optional prescale of 8. The second is a character divisor. The third is a per-bit divisor plus one. A divisor of zero stops the tick.

The block also works out how many bit times one character frame takes from the mode fields. That count covers the start bit, the data width, an optional parity bit and the stop bits. Each received character restarts a countdown of four frame lengths, measured in bit ticks. When the countdown runs out, the block pulses `rx_timeout`.

All configuration is taken in on a `cfg_load` strobe. Until the first load, the divisor is 15 and the frame is 10 bits long.

Top module: `uart_baud_timeout`

## Requirements
- R1: After reset, `baud_tick` and `rx_timeout` are low and `frame_bits` is 10. Ticks are then spaced 15 clocks apart, because the reset values are divisor 15, per-bit divisor 0 and no prescale.
- R2: With `clk_div8`=0, consecutive `baud_tick` pulses are `cd`×(`bdiv`+1) clocks apart.
- R3: With `clk_div8`=1, the spacing becomes 8×`cd`×(`bdiv`+1) clocks.
- R4: A loaded `cd` of 0 produces no `baud_tick` at all.
- R5: Data width code: 3 gives 6 bits, 2 gives 7 bits, and codes 0 and 1 give 8 bits.
- R6: Parity code 0 (even) or 1 (odd) adds one bit to the frame. Codes 2 to 7 add none.
- R7: Stop code 2 gives two stop bits. Every other code gives one. `frame_bits` = 1 + data + parity + stop.
- R8: Configuration inputs have no effect unless `cfg_load` is high. `frame_bits` and the tick spacing keep their old values.
- R9: `rx_timeout` pulses for exactly one clock, one clock after the 4×`frame_bits`-th tick that follows the last `rx_char`.
- R10: An `rx_char` before expiry restarts the countdown. This includes an `rx_char` taken in the same cycle as the tick that would have ended it. No pulse is produced for the old countdown.
- R11: After a timeout pulse, no further pulse occurs until another `rx_char` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Captures all configuration inputs |
| clk_div8 | input | 1 | Selects the clock divided by 8 as the tick source |
| data_code | input | 2 | Data width code |
| par_code | input | 3 | Parity code |
| stop_code | input | 2 | Stop-bit code |
| cd_in | input | CD_W | Character divisor; 0 stops the tick |
| bdiv_in | input | BDIV_W | Per-bit divisor, used as value+1 |
| rx_char | input | 1 | One-clock pulse for each received character |
| baud_tick | output | 1 | One-clock bit-rate tick |
| rx_timeout | output | 1 | One-clock idle timeout event |
| frame_bits | output | 4 | Current frame length in bits |

## Verification
A character arrival and the final countdown tick can land in the same clock cycle. In that case the arrival must win: the countdown restarts and no pulse is produced. The bench provokes this by counting ticks after a character and raising `rx_char` in exactly the cycle where the last required tick is high. A scoreboard model predicts every timeout cycle. Any pulse the model does not expect is judged a failure, and so is any predicted pulse that never appears.

// File: rtl/uart_baud_timeout.sv
module uart_baud_timeout #(
  parameter int CD_W   = 16,
  parameter int BDIV_W = 8,
  parameter int CD_RST = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic              clk_div8,
  input  logic [1:0]        data_code,
  input  logic [2:0]        par_code,
  input  logic [1:0]        stop_code,
  input  logic [CD_W-1:0]   cd_in,
  input  logic [BDIV_W-1:0] bdiv_in,
  input  logic              rx_char,
  output logic              baud_tick,
  output logic              rx_timeout,
  output logic [3:0]        frame_bits
);
  localparam int FRAME_MAX = 12;
  localparam int TO_W = $clog2(4 * FRAME_MAX + 1);

  logic              sel_q;
  logic [CD_W-1:0]   cd_q, cd_cnt;
  logic [BDIV_W-1:0] bdiv_q, bd_cnt;
  logic [2:0]        pre_cnt;
  logic [TO_W-1:0]   to_cnt;
  logic              armed;

  logic       pre_en, cd_hit, bd_hit;
  logic [3:0] new_frame;

  assign pre_en = !sel_q || (pre_cnt == 3'd7);
  assign cd_hit = pre_en && (cd_q != '0) && (cd_cnt >= cd_q - CD_W'(1));
  assign bd_hit = bd_cnt >= bdiv_q;

  assign new_frame = 4'd1
                   + ((data_code == 2'd3) ? 4'd6 : (data_code == 2'd2) ? 4'd7 : 4'd8)
                   + ((par_code <= 3'd1) ? 4'd1 : 4'd0)
                   + ((stop_code == 2'd2) ? 4'd2 : 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q      <= 1'b0;
      cd_q       <= CD_W'(CD_RST);
      bdiv_q     <= '0;
      frame_bits <= 4'd10;
    end else if (cfg_load) begin
      sel_q      <= clk_div8;
      cd_q       <= cd_in;
      bdiv_q     <= bdiv_in;
      frame_bits <= new_frame;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt   <= '0;
      cd_cnt    <= '0;
      bd_cnt    <= '0;
      baud_tick <= 1'b0;
    end else begin
      pre_cnt   <= pre_cnt + 3'd1;
      baud_tick <= cd_hit && bd_hit;
      if (cd_q == '0) begin
        cd_cnt <= '0;
        bd_cnt <= '0;
      end else if (pre_en) begin
        cd_cnt <= cd_hit ? '0 : cd_cnt + CD_W'(1);
        if (cd_hit) bd_cnt <= bd_hit ? '0 : bd_cnt + BDIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      to_cnt     <= '0;
      armed      <= 1'b0;
      rx_timeout <= 1'b0;
    end else begin
      rx_timeout <= 1'b0;
      if (rx_char) begin
        to_cnt <= TO_W'({frame_bits, 2'b00});
        armed  <= 1'b1;
      end else if (armed && baud_tick) begin
        if (to_cnt == TO_W'(1)) begin
          armed      <= 1'b0;
          rx_timeout <= 1'b1;
        end else begin
          to_cnt <= to_cnt - TO_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/uart_baud_timeout_chk.sv
module uart_baud_timeout_chk #(
  parameter int CD_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_load,
  input logic            rx_char,
  input logic            baud_tick,
  input logic            rx_timeout,
  input logic [3:0]      frame_bits,
  input logic [CD_W-1:0] cd_q
);
  a_r4_no_tick_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_q == '0) |=> !baud_tick);
  a_r7_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_bits >= 4'd8) && (frame_bits <= 4'd12));
  a_r8_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(frame_bits));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout |=> !rx_timeout);
  a_r9_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_timeout) |-> $past(baud_tick));
  a_r10_char_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rx_char |=> !rx_timeout);
endmodule

bind uart_baud_timeout uart_baud_timeout_chk #(.CD_W(CD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .rx_char(rx_char),
  .baud_tick(baud_tick), .rx_timeout(rx_timeout), .frame_bits(frame_bits),
  .cd_q(cd_q)
);

// File: tb/tb_uart_baud_timeout.sv
module tb_uart_baud_timeout;
  logic clk = 1'b0, rst_n = 1'b0, cfg_load = 1'b0, clk_div8 = 1'b0, rx_char = 1'b0;
  logic [1:0] data_code = 2'd0, stop_code = 2'd0;
  logic [2:0] par_code = 3'd4;
  logic [15:0] cd_in = 16'd15;
  logic [7:0] bdiv_in = 8'd0;
  logic baud_tick, rx_timeout;
  logic [3:0] frame_bits;

  int checks = 0, errors = 0, cyc = 0, tcount = 0, m_frame = 10, m_cnt = 0;
  bit m_armed = 0, done = 0;
  int expq[$];

  always #4 clk = ~clk;

  uart_baud_timeout dut (.*);

  function automatic int frame_of(int d, int p, int s);
    return 1 + (d == 3 ? 6 : d == 2 ? 7 : 8) + (p <= 1 ? 1 : 0) + (s == 2 ? 2 : 1);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor and scoreboard for the idle timeout
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_timeout) begin
        tcount++;
        if (expq.size() == 0) check("R11 unexpected timeout", cyc, -1);
        else check("R9 timeout cycle", cyc, expq.pop_front());
      end
      if (rx_char) begin
        m_armed = 1; m_cnt = 4 * m_frame;
      end else if (m_armed && baud_tick) begin
        m_cnt--;
        if (m_cnt == 0) begin m_armed = 0; expq.push_back(cyc + 1); end
      end
    end
    cyc++;
  end

  task automatic cfg(bit s8, int d, int p, int s, int cd, int bd);
    @(posedge clk); #1;
    clk_div8 = s8; data_code = 2'(d); par_code = 3'(p); stop_code = 2'(s);
    cd_in = 16'(cd); bdiv_in = 8'(bd); cfg_load = 1'b1;
    @(posedge clk); #1; cfg_load = 1'b0;
    m_frame = frame_of(d, p, s);
  endtask

  task automatic send_char();
    @(posedge clk); #1 rx_char = 1'b1;
    @(posedge clk); #1 rx_char = 1'b0;
  endtask

  task automatic period(string tag, int exp);
    int n = 0;
    for (int i = 0; i < 5000 && !baud_tick; i++) @(negedge clk);
    @(negedge clk); n = 1;
    while (!baud_tick && n < 5000) begin @(negedge clk); n++; end
    check(tag, n, exp);
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int t0;
    int k;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 tick low", baud_tick, 0);
    check("R1 timeout low", rx_timeout, 0);
    check("R1 frame 10", frame_bits, 10);
    period("R1 reset period", 15);

    cfg(0, 0, 4, 0, 3, 2);
    period("R2 period 3x3", 9);
    cfg(0, 0, 4, 0, 5, 0);
    period("R2 period 5x1", 5);
    cfg(1, 0, 4, 0, 2, 1);
    period("R3 prescaled period", 32);

    cfg(0, 0, 4, 0, 0, 0);
    t0 = 0;
    for (int i = 0; i < 2000; i++) begin @(negedge clk); if (baud_tick) t0++; end
    check("R4 ticks with cd 0", t0, 0);

    cfg(0, 3, 0, 2, 2, 1);
    @(negedge clk); check("R5 R6 R7 frame 6E2", frame_bits, 10);
    cfg(0, 2, 1, 3, 2, 1);
    @(negedge clk); check("R5 R6 frame 7O1", frame_bits, 10);
    cfg(0, 1, 0, 2, 2, 1);
    @(negedge clk); check("R7 frame 8E2", frame_bits, 12);
    cfg(0, 3, 7, 3, 2, 1);
    @(negedge clk); check("R5 R6 frame 6N1", frame_bits, 8);

    @(posedge clk); #1;
    data_code = 2'd0; par_code = 3'd0; stop_code = 2'd2; cd_in = 16'd9; clk_div8 = 1'b1;
    wait_cycles(3);
    @(negedge clk); check("R8 frame held", frame_bits, 8);
    period("R8 period held", 4);

    // timeout with frame 8: 32 ticks of 4 clocks
    t0 = tcount;
    send_char();
    wait_cycles(200);
    check("R9 one timeout", tcount - t0, 1);
    wait_cycles(400);
    check("R11 no repeat", tcount - t0, 1);

    // restart before expiry
    t0 = tcount;
    send_char();
    wait_cycles(80);
    send_char();
    wait_cycles(80);
    check("R10 restart pending", tcount - t0, 0);
    wait_cycles(100);
    check("R10 restart fired once", tcount - t0, 1);

    // char in same cycle as final tick
    cfg(0, 1, 0, 2, 2, 1);
    t0 = tcount;
    send_char();
    k = 0;
    forever begin
      if (baud_tick) k++;
      if (k == 48) begin rx_char = 1'b1; break; end
      @(posedge clk); #1;
    end
    @(posedge clk); #1 rx_char = 1'b0;
    wait_cycles(20);
    check("R10 coincident char suppresses", tcount - t0, 0);
    wait_cycles(250);
    check("R10 coincident restart fires", tcount - t0, 1);

    wait_cycles(10);
    check("R9 queue drained", expq.size(), 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule